// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block runs the digital half of a successive-approximation analog-to-digital converter. It drives a parallel trial code into an external resistor-ladder DAC and reads one comparator bit. The comparator reports whether the sampled input is at or above the ladder voltage. The block searches for the input value one bit at a time, from the most significant bit down to the least. It waits a programmable number of settling cycles before each comparator reading. It also drives the control line of an external track-and-hold switch.

A single-cycle `start_i` pulse begins a conversion while the block is idle. After `WIDTH` trials the final code is copied into the result register, and `done_o` pulses for one cycle. The controller is a five-state machine:

- **IDLE:** the switch tracks and `start_i` is accepted. Transition *launch* goes to TRIAL and clears the code.
- **TRIAL:** ORs the current bit of a one-hot selector into the code. Transition *drive* goes to SETTLE.
- **SETTLE:** lasts `SETTLE_CYC` cycles. Transition *settled* goes to SAMPLE.
- **SAMPLE:** keeps or clears the trial bit and shifts the selector right. Transition *next* returns to TRIAL. When the selector shifts out past the least significant bit, transition *finish* goes to DONE.
- **DONE:** lasts one cycle. Transition *retire* returns to IDLE.

`WIDTH` may be set to 8, 10 or 12.

Top module: `sar_conv_ctrl`

## Requirements
- R1: During and directly after reset: `dac_code_o` = 0, `result_o` = 0, `busy_o` = 0, `done_o` = 0 and `track_o` = 1.
- R2: A start accepted at a clock edge drives `dac_code_o` to all zeros for the following cycle. In the cycle after that, the first trial code is driven, which has only bit `WIDTH-1` set.
- R3: Bits are tried one at a time from bit `WIDTH-1` down to bit 0. Each trial code is held for `SETTLE_CYC` cycles plus one sample cycle, and the comparator is read only in that sample cycle. A comparator whose output lags the code by `SETTLE_CYC` cycles still yields the correct result.
- R4: `cmp_i` = 1 in the sample cycle keeps the trial bit, and `cmp_i` = 0 clears it. For an ideal comparator (`cmp_i` = input ≥ code), the result equals the input value. This includes the values 0 and all ones.
- R5: The conversion ends after exactly `WIDTH` trials. `done_o` is high in the cycle that begins `WIDTH*(SETTLE_CYC+2)` clock edges after the start edge.
- R6: `done_o` is high for exactly one cycle per conversion. While it is high, `result_o` equals the final `dac_code_o`.
- R7: `busy_o` is high from the cycle after the start edge through the `done_o` cycle, and low otherwise.
- R8: `track_o` = 1 (switch closed, tracking) whenever `busy_o` = 0, and `track_o` = 0 (switch open, holding) whenever `busy_o` = 1.
- R9: A `start_i` pulse while `busy_o` = 1 is ignored. It causes no extra `done_o`, no change in timing and no change in result.
- R10: `result_o` keeps its value until the next conversion completes, including throughout a later conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request pulse |
| dac_code_o | output | WIDTH | Trial code to the ladder DAC |
| cmp_i | input | 1 | Comparator: 1 = input at or above ladder voltage |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Last completed conversion result |
| track_o | output | 1 | Switch control: 1 = track, 0 = hold |

## Verification
If the one-hot selector or the code register is corrupted, the result returned to the scoreboard is wrong as soon as `done_o` rises, and the offset of the wrong bit points at the faulty step. If the state machine or the settle counter goes wrong, `done_o` fires on the wrong cycle or twice, which is caught within one conversion time. The bench's comparator model lags the code, so a controller that samples before the settle time has elapsed returns wrong bits at once. Stray pulses on `start_i` while busy, together with a long wait between conversions, expose an accepted restart or a leaking result register within one conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRIAL,
        ST_SETTLE,
        ST_SAMPLE,
        ST_DONE
    } sar_state_e;

endpackage

// File: rtl/sar_bit_selector.sv
// One-hot trial-bit selector: loads at the top bit and walks toward bit 0.
module sar_bit_selector #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             shift_i,
    output logic [WIDTH-1:0] mask_o,
    output logic             last_o
);

    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else if (load_i) begin
            mask_q <= TOP_BIT;
        end else if (shift_i) begin
            mask_q <= mask_q >> 1;
        end
    end

    assign mask_o = mask_q;
    // the bit about to fall out of the selector marks the final trial
    assign last_o = mask_q[0];

endmodule

// File: rtl/sar_settle_timer.sv
// Counts the cycles a trial code is held before the comparator is read.
module sar_settle_timer #(
    parameter int SETTLE_CYC = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);

    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != LAST_CNT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LAST_CNT);

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int SETTLE_CYC = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic [WIDTH-1:0] dac_code_o,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o,
    output logic             track_o
);

    sar_state_e       state_q, state_d;
    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] result_q;
    logic [WIDTH-1:0] mask;
    logic             last_bit;
    logic             settled;
    logic [WIDTH-1:0] code_judged;

    // control strobes decoded from the state
    logic launch, drive, sample;

    assign launch = (state_q == ST_IDLE) && start_i;
    assign drive  = (state_q == ST_TRIAL);
    assign sample = (state_q == ST_SAMPLE);

    sar_bit_selector #(.WIDTH(WIDTH)) u_sel (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (launch),
        .shift_i (sample),
        .mask_o  (mask),
        .last_o  (last_bit)
    );

    sar_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (drive),
        .run_i     (state_q == ST_SETTLE),
        .expired_o (settled)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_TRIAL;
            ST_TRIAL:  state_d = ST_SETTLE;
            ST_SETTLE: if (settled) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = last_bit ? ST_DONE : ST_TRIAL;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // trial bit survives only when the comparator reads high
    assign code_judged = cmp_i ? code_q : (code_q & ~mask);

    // code and result registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_q   <= '0;
            result_q <= '0;
        end else begin
            if (launch) begin
                code_q <= '0;
            end else if (drive) begin
                code_q <= code_q | mask;
            end else if (sample) begin
                code_q <= code_judged;
            end
            if (sample && last_bit) begin
                result_q <= code_judged;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o  = 1'b1;
        done_o  = 1'b0;
        track_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o  = 1'b0;
                track_o = 1'b1;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign dac_code_o = code_q;
    assign result_o   = result_q;

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [WIDTH-1:0] dac_code_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] result_o,
    input logic             track_o
);

    p_start_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (dac_code_o == '0));

    p_msb_trial_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |=> (dac_code_o == {1'b1, {(WIDTH-1){1'b0}}}));

    p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (result_o == dac_code_o));

    p_done_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> busy_o);

    p_track_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> track_o);

    p_hold_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !track_o);

    p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o && start_i) |=> busy_o);

    p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dac_code_o (dac_code_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .track_o    (track_o)
);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;

    localparam int W      = 8;
    localparam int N      = 1;
    localparam int LAT    = W * (N + 2);
    localparam int MAXV   = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dac_code;
    logic [W-1:0] dac_d;
    logic         cmp;
    logic         busy, done, track;
    logic [W-1:0] result;
    logic [W-1:0] vin = '0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    int exp_q[$];
    int start_q[$];
    bit prev_done = 0;

    always #10 clk = ~clk;

    // comparator that sees the code one cycle late (settling model)
    always @(posedge clk) begin
        dac_d <= dac_code;
        cyc   <= cyc + 1;
    end
    assign cmp = (vin >= dac_d);

    sar_conv_ctrl #(.WIDTH(W), .SETTLE_CYC(N)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .dac_code_o (dac_code),
        .cmp_i      (cmp),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result),
        .track_o    (track)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard on each done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                check("R6 done single cycle", int'(prev_done), 0);
                check("R6 result equals code", int'(result), int'(dac_code));
                check("R7 busy in done cycle", int'(busy), 1);
                if (exp_q.size() == 0) begin
                    check("R9 spurious done", 1, 0);
                end else begin
                    check("R4 result value", int'(result), exp_q.pop_front());
                    check("R5 latency", cyc - start_q.pop_front(), LAT);
                end
            end
            prev_done = done;
        end
    end

    // driver: one conversion, optional stray start while busy
    task automatic convert(input int v, input bit stray);
        @(negedge clk);
        vin   = W'(v);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        exp_q.push_back(v);
        start_q.push_back(cyc);
        check("R2 code cleared", int'(dac_code), 0);
        check("R7 busy after start", int'(busy), 1);
        check("R8 switch opens", int'(track), 0);
        @(negedge clk);
        check("R2 first trial msb", int'(dac_code), 1 << (W - 1));
        if (stray) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        check("R8 tracking in idle", int'(track), 1);
        check("R7 busy low after done", int'(done), 0);
        repeat (3) @(negedge clk);
        check("R9 no restart", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 code in reset", int'(dac_code), 0);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 track in reset", int'(track), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 result after reset", int'(result), 0);
        check("R1 done after reset", int'(done), 0);

        // R3 R4 corner and pattern values
        convert(0, 0);
        convert(MAXV, 0);
        convert(1 << (W - 1), 0);
        convert((1 << (W - 1)) - 1, 0);
        convert(1, 0);
        convert(8'hAA, 0);
        convert(8'h55, 0);
        for (int i = 0; i < 8; i++) begin
            convert(int'($urandom_range(MAXV)), 0);
        end

        // R9 stray start mid conversion
        convert(8'h3C, 1);

        // R10 result held while idle and during the next conversion
        vin = 8'h11;
        repeat (10) @(negedge clk);
        check("R10 hold while idle", int'(result), 8'h3C);
        @(negedge clk);
        vin   = 8'hE7;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        exp_q.push_back(8'hE7);
        start_q.push_back(cyc);
        repeat (LAT / 2) @(negedge clk);
        check("R10 hold during conversion", int'(result), 8'h3C);
        while (busy) @(negedge clk);
        check("R10 updated on completion", int'(result), 8'hE7);
        check("R6 scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule